// File: doc/BRIEF.md
# Dual-Channel Instruction Breakpoint Unit

This unit watches the instruction-fetch stream of a processor and raises a break request when programmed match conditions are met. It has two channels. Each one holds a compare address, an address mask whose set bits are ignored, an optional compare against the fetch's 8-bit address-space identifier (ASID), and a bit that picks whether the break is taken before the matched instruction runs or after it has executed. Channel 1 can also compare a masked copy of the fetched data word, and it can count its matches so that it only reports the Nth one.

The channels either work side by side, where a match on either one causes a break, or as a chain, where a channel-0 match only arms the unit and a later channel-1 match causes the break. A before-execution break is flagged in the same cycle as the fetch. An after-execution break waits for the execute-complete strobe. Once raised, the break request stays high until a clear input acknowledges it. Software or a debug agent sets the unit up through a simple word-wide register write port.

Top module: `fetch_break_unit`

## Requirements
- R1: After reset `brkReq` is 0, `chMatch` is 0, both channels are disabled, the chained mode is off and the match counter is 0.
- R2: Register offsets are: 0 = channel-0 control, 1 = channel-0 address, 2 = channel-0 mask, 3 = channel-1 control, 4 = channel-1 address, 5 = channel-1 mask, 6 = channel-1 data, 7 = channel-1 data mask, 8 = match-count load, 9 = mode (bit 0 = chained). Control bits are: bit 0 enable, bit 1 after-execution, bit 2 ASID compare on, bit 3 data compare on (channel 1 only), bit 4 counting on (channel 1 only), bits 15:8 the ASID. An address matches when it equals the compare address on every bit whose mask bit is 0. For example, compare 0x8010 with mask 0x6 matches 0x8010, 0x8012, 0x8014 and 0x8016, but does not match 0x8011 or 0x8018.
- R3: With ASID compare on, a channel matches only if `fetchAsid` equals its programmed ASID. With ASID compare off, the ASID is ignored.
- R4: With data compare on, channel 1 matches only if `fetchData` equals the data register on every bit that is 0 in the data mask. With data compare off, `fetchData` is ignored.
- R5: With counting on, each channel-1 match decrements the counter, which stops at 0. Channel 1 reports a match only when the counter is 1 or 0 at that match. A write to offset 8 loads the counter.
- R6: A disabled channel never reports a match, never causes a break and never arms the chained mode.
- R7: With chained mode off, a reported match on either channel causes a break.
- R8: With chained mode on, a channel-0 match arms the unit. A channel-1 match in a later cycle while armed causes a break, timed by channel 1's before/after bit. A channel-1 match while not armed causes no break.
- R9: The armed state clears when the chained break is triggered and on any register write.
- R10: A before-execution break drives `brkReq` high in the same cycle as the qualifying fetch.
- R11: An after-execution break is held pending and drives `brkReq` high in the first later cycle with `execDone` high.
- R12: `brkReq` stays high until a cycle with `brkClr` high. A new trigger in the clearing cycle keeps it high.
- R13: When `fetchValid` is low, no channel reports a match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fetchValid | input | 1 | A fetch is present this cycle |
| fetchAddr | input | ADDR_W | Fetch address |
| fetchAsid | input | ASID_W | Fetch address-space identifier |
| fetchData | input | DATA_W | Fetched data word |
| execDone | input | 1 | Execute-complete strobe for the oldest fetched instruction |
| regWe | input | 1 | Register write enable |
| regAddr | input | 4 | Register offset |
| regWdata | input | REG_W | Register write data |
| brkClr | input | 1 | Acknowledge and clear the break request |
| brkReq | output | 1 | Break request |
| chMatch | output | 2 | Per-channel match flags for this cycle |

## Verification
The bench builds the unit with a 32-bit address, a 16-bit data word, an 8-bit ASID and a 4-bit counter. The 4-bit counter keeps loads of 3 and the stop-at-zero behaviour within a few fetches. The 16-bit data word lets a byte mask split each compare into a checked half and an ignored half. A reference model with the same parameters runs through directed address, ASID, data, counting and chaining cases, and then through a long stretch of random fetches, strobes, clears and register rewrites.

// File: rtl/fbu_pkg.sv
package fbu_pkg;
  // offsets of the configuration registers
  localparam int OFS_CTRL0 = 0;
  localparam int OFS_ADDR0 = 1;
  localparam int OFS_MASK0 = 2;
  localparam int OFS_CTRL1 = 3;
  localparam int OFS_DATA1 = 6;
  localparam int OFS_DMASK = 7;
  localparam int OFS_COUNT = 8;
  localparam int OFS_MODE  = 9;
  localparam int CH_STRIDE = 3;

  // datapath -> control: raw compare results and configuration
  typedef struct packed {
    logic hit0;
    logic raw1;
    logic cntEn;
    logic cntLast;
    logic after0;
    logic after1;
    logic seqMode;
    logic cfgWrite;
  } matchInfo_t;

  // control -> datapath strobes
  typedef struct packed {
    logic cntDec;
  } ctlStrobe_t;
endpackage

// File: rtl/fbu_datapath.sv
module fbu_datapath
  import fbu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 12,
  parameter int ASID_W = 8,
  parameter int REG_W  = 32,
  parameter int RA_W   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fetchValid,
  input  logic [ADDR_W-1:0] fetchAddr,
  input  logic [ASID_W-1:0] fetchAsid,
  input  logic [DATA_W-1:0] fetchData,
  input  logic              regWe,
  input  logic [RA_W-1:0]   regAddr,
  input  logic [REG_W-1:0]  regWdata,
  input  ctlStrobe_t        strobe,
  output matchInfo_t        info
);
  localparam int ASID_LO = 8;
  localparam int ASID_HI = ASID_LO + ASID_W - 1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [1:0] chHit;
  logic [1:0] chAfter;

  generate
    for (genvar c = 0; c < 2; c++) begin : g_ch
      localparam int BASE = c * CH_STRIDE;
      logic              enQ, afterQ, asidEnQ;
      logic [ASID_W-1:0] asidQ;
      logic [ADDR_W-1:0] addrQ, maskQ;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          enQ     <= 1'b0;
          afterQ  <= 1'b0;
          asidEnQ <= 1'b0;
          asidQ   <= '0;
          addrQ   <= '0;
          maskQ   <= '0;
        end else if (regWe) begin
          if (regAddr == RA_W'(BASE)) begin
            enQ     <= regWdata[0];
            afterQ  <= regWdata[1];
            asidEnQ <= regWdata[2];
            asidQ   <= regWdata[ASID_HI:ASID_LO];
          end
          if (regAddr == RA_W'(BASE + 1)) addrQ <= regWdata[ADDR_W-1:0];
          if (regAddr == RA_W'(BASE + 2)) maskQ <= regWdata[ADDR_W-1:0];
        end
      end

      assign chHit[c]   = fetchValid && enQ
                          && (((fetchAddr ^ addrQ) & ~maskQ) == '0)
                          && (!asidEnQ || fetchAsid == asidQ);
      assign chAfter[c] = afterQ;
    end
  endgenerate

  // channel-1 extra terms and global mode
  logic              dataEnQ, cntEnQ, seqQ;
  logic [DATA_W-1:0] dataQ, dmaskQ;
  logic [CNT_W-1:0]  cntQ;
  logic              dataOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataEnQ <= 1'b0;
      cntEnQ  <= 1'b0;
      seqQ    <= 1'b0;
      dataQ   <= '0;
      dmaskQ  <= '0;
    end else if (regWe) begin
      if (regAddr == RA_W'(OFS_CTRL1)) begin
        dataEnQ <= regWdata[3];
        cntEnQ  <= regWdata[4];
      end
      if (regAddr == RA_W'(OFS_DATA1)) dataQ  <= regWdata[DATA_W-1:0];
      if (regAddr == RA_W'(OFS_DMASK)) dmaskQ <= regWdata[DATA_W-1:0];
      if (regAddr == RA_W'(OFS_MODE))  seqQ   <= regWdata[0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                      cntQ <= '0;
    else if (regWe && regAddr == RA_W'(OFS_COUNT))  cntQ <= regWdata[CNT_W-1:0];
    else if (strobe.cntDec && cntQ != '0)           cntQ <= cntQ - CNT_ONE;
  end

  assign dataOk = !dataEnQ || (((fetchData ^ dataQ) & ~dmaskQ) == '0);

  always_comb begin
    info.hit0     = chHit[0];
    info.raw1     = chHit[1] && dataOk;
    info.cntEn    = cntEnQ;
    info.cntLast  = (cntQ <= CNT_ONE);
    info.after0   = chAfter[0];
    info.after1   = chAfter[1];
    info.seqMode  = seqQ;
    info.cfgWrite = regWe;
  end

  // R5: a decrement request at zero leaves the counter at zero
  a_r5_cnt_floor: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.cntDec && cntQ == '0 && !regWe) |=> (cntQ == '0));
endmodule

// File: rtl/fbu_control.sv
module fbu_control
  import fbu_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  matchInfo_t info,
  input  logic       execDone,
  input  logic       brkClr,
  output ctlStrobe_t strobe,
  output logic       brkReq,
  output logic [1:0] chMatch
);
  logic armedQ, pendQ, latchQ;
  logic hit1, seqTrig, trigBefore, trigAfter, fire;

  always_comb begin
    hit1    = info.raw1 && (!info.cntEn || info.cntLast);
    seqTrig = info.seqMode && armedQ && hit1;
    if (info.seqMode) begin
      trigBefore = seqTrig && !info.after1;
      trigAfter  = seqTrig &&  info.after1;
    end else begin
      trigBefore = (info.hit0 && !info.after0) || (hit1 && !info.after1);
      trigAfter  = (info.hit0 &&  info.after0) || (hit1 &&  info.after1);
    end
    fire          = trigBefore || (pendQ && execDone);
    strobe.cntDec = info.raw1 && info.cntEn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armedQ <= 1'b0;
      pendQ  <= 1'b0;
      latchQ <= 1'b0;
    end else begin
      if (info.cfgWrite || seqTrig)           armedQ <= 1'b0;
      else if (info.seqMode && info.hit0)     armedQ <= 1'b1;
      pendQ  <= trigAfter || (pendQ && !execDone && !brkClr);
      latchQ <= fire || (latchQ && !brkClr);
    end
  end

  assign brkReq  = latchQ || fire;
  assign chMatch = {hit1, info.hit0};

  // R12: the request holds until acknowledged
  a_r12_hold: assert property (@(posedge clk) disable iff (!rstN)
    (brkReq && !brkClr) |=> brkReq);
  // R9: any register write leaves the unit disarmed
  a_r9_write_disarms: assert property (@(posedge clk) disable iff (!rstN)
    info.cfgWrite |=> !armedQ);
  // R8: in chained mode a fresh break from a fetch needs the armed state
  a_r8_chain_needs_arm: assert property (@(posedge clk) disable iff (!rstN)
    (info.seqMode && $rose(brkReq) && !execDone) |-> armedQ);
  // R10, R11: a new request has a fetch hit or an execute strobe behind it
  a_r11_rise_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(brkReq) |-> (info.hit0 || info.raw1 || execDone));
endmodule

// File: rtl/fetch_break_unit.sv
module fetch_break_unit
  import fbu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 12,
  parameter int ASID_W = 8,
  parameter int REG_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fetchValid,
  input  logic [ADDR_W-1:0] fetchAddr,
  input  logic [ASID_W-1:0] fetchAsid,
  input  logic [DATA_W-1:0] fetchData,
  input  logic              execDone,
  input  logic              regWe,
  input  logic [3:0]        regAddr,
  input  logic [REG_W-1:0]  regWdata,
  input  logic              brkClr,
  output logic              brkReq,
  output logic [1:0]        chMatch
);
  matchInfo_t info;
  ctlStrobe_t strobe;

  fbu_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
    .ASID_W(ASID_W), .REG_W(REG_W), .RA_W(4)
  ) u_dp (
    .clk(clk), .rstN(rstN), .fetchValid(fetchValid), .fetchAddr(fetchAddr),
    .fetchAsid(fetchAsid), .fetchData(fetchData), .regWe(regWe),
    .regAddr(regAddr), .regWdata(regWdata), .strobe(strobe), .info(info)
  );

  fbu_control u_ctl (
    .clk(clk), .rstN(rstN), .info(info), .execDone(execDone),
    .brkClr(brkClr), .strobe(strobe), .brkReq(brkReq), .chMatch(chMatch)
  );

  // R13: without a valid fetch nothing is flagged
  a_r13_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !fetchValid |-> (chMatch == 2'b00));
endmodule

// File: tb/fetch_break_unit_tb.sv
module fetch_break_unit_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        fetchValid = 1'b0;
  logic [31:0] fetchAddr = '0;
  logic [7:0]  fetchAsid = '0;
  logic [15:0] fetchData = '0;
  logic        execDone = 1'b0;
  logic        regWe = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic        brkClr = 1'b0;
  logic        brkReq;
  logic [1:0]  chMatch;

  always #5 clk = ~clk;

  fetch_break_unit #(.ADDR_W(32), .DATA_W(16), .CNT_W(4), .ASID_W(8), .REG_W(32)) u_dut (
    .clk(clk), .rstN(rstN), .fetchValid(fetchValid), .fetchAddr(fetchAddr),
    .fetchAsid(fetchAsid), .fetchData(fetchData), .execDone(execDone),
    .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata), .brkClr(brkClr),
    .brkReq(brkReq), .chMatch(chMatch)
  );

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;
  string curReq = "R1";

  // reference model state
  logic [31:0] mr [10];
  int  mcnt = 0;
  bit  mArmed = 0, mPend = 0, mLatch = 0;
  bit  eH0, eR1, eH1, eSeqTrig, eTrigB, eTrigA, eFire, eReq;

  task automatic evalModel();
    bit seq;
    seq = mr[9][0];
    eH0 = fetchValid && mr[0][0] && (((fetchAddr ^ mr[1]) & ~mr[2]) == 0)
          && (!mr[0][2] || fetchAsid == mr[0][15:8]);
    eR1 = fetchValid && mr[3][0] && (((fetchAddr ^ mr[4]) & ~mr[5]) == 0)
          && (!mr[3][2] || fetchAsid == mr[3][15:8])
          && (!mr[3][3] || ((fetchData ^ mr[6][15:0]) & ~mr[7][15:0]) == 0);
    eH1 = eR1 && (!mr[3][4] || mcnt <= 1);
    eSeqTrig = 0;
    if (seq) begin
      eSeqTrig = mArmed && eH1;
      eTrigB = eSeqTrig && !mr[3][1];
      eTrigA = eSeqTrig && mr[3][1];
    end else begin
      eTrigB = (eH0 && !mr[0][1]) || (eH1 && !mr[3][1]);
      eTrigA = (eH0 && mr[0][1]) || (eH1 && mr[3][1]);
    end
    eFire = eTrigB || (mPend && execDone);
    eReq  = mLatch || eFire;
  endtask

  task automatic updModel();
    if (regWe) mArmed = 0;
    else if (eSeqTrig) mArmed = 0;
    else if (mr[9][0] && eH0) mArmed = 1;
    mPend  = eTrigA || (mPend && !execDone && !brkClr);
    mLatch = eFire || (mLatch && !brkClr);
    if (eR1 && mr[3][4] && mcnt > 0) mcnt--;
    if (regWe && regAddr == 4'd8) mcnt = int'(regWdata[3:0]);
    if (regWe && regAddr < 4'd10) mr[regAddr] = regWdata;
  endtask

  task automatic tick();
    #1;
    evalModel();
    vectors++;
    if (brkReq !== eReq || chMatch !== {eH1, eH0}) begin
      fails++;
      $display("FAIL %s t=%0t: brkReq=%b chMatch=%b expected brkReq=%b chMatch=%b",
               curReq, $time, brkReq, chMatch, eReq, {eH1, eH0});
    end
    @(posedge clk);
    updModel();
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    regWe = 1; regAddr = a; regWdata = d;
    tick();
    regWe = 0;
  endtask

  task automatic fetch(input logic [31:0] a, input logic [7:0] asid = 8'h00,
                       input logic [15:0] d = 16'h0000, input bit ex = 0);
    fetchValid = 1; fetchAddr = a; fetchAsid = asid; fetchData = d; execDone = ex;
    tick();
    fetchValid = 0; execDone = 0;
  endtask

  task automatic clr();
    brkClr = 1;
    tick();
    brkClr = 0;
  endtask

  initial begin
    #500000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 10; i++) mr[i] = '0;
    repeat (3) @(negedge clk);
    curReq = "R1";
    vectors++;
    if (brkReq !== 1'b0 || chMatch !== 2'b00) begin
      fails++;
      $display("FAIL R1 reset: brkReq=%b chMatch=%b expected 0 00", brkReq, chMatch);
    end
    rstN = 1;
    @(negedge clk);
    fetch(32'h8010);            // R1: disabled channels stay quiet

    curReq = "R2";
    wr(0, 32'h1); wr(1, 32'h8010); wr(2, 32'h6);
    fetch(32'h8010); clr();
    fetch(32'h8016); clr();
    fetch(32'h8014); clr();
    fetch(32'h8018); fetch(32'h8011);

    curReq = "R13";
    fetchAddr = 32'h8010; tick(); tick();

    curReq = "R3";
    wr(0, 32'h8005);
    fetch(32'h8010, 8'h70); fetch(32'h8010, 8'h80); clr();

    curReq = "R6";
    wr(0, 32'h8004);
    fetch(32'h8010, 8'h80); fetch(32'h8012, 8'h80);

    curReq = "R4";
    wr(3, 32'h9); wr(4, 32'h404); wr(5, 32'h0); wr(6, 32'hAB00); wr(7, 32'hFF);
    fetch(32'h404, 8'h00, 16'hAB12); clr();
    fetch(32'h404, 8'h00, 16'hAC12);
    wr(3, 32'h1);
    fetch(32'h404, 8'h00, 16'hAC12); clr();

    curReq = "R5";
    wr(3, 32'h11); wr(8, 32'h3);
    fetch(32'h404); fetch(32'h404); fetch(32'h404); clr();
    fetch(32'h404); clr();

    curReq = "R7";
    wr(0, 32'h1); wr(3, 32'h1);
    fetch(32'h8012); clr();
    fetch(32'h404); clr();

    curReq = "R8";
    wr(9, 32'h1);
    fetch(32'h404);             // not armed: no break
    fetch(32'h8010);            // arms
    tick();
    fetch(32'h404); clr();      // break

    curReq = "R9";
    fetch(32'h404);             // disarmed by the trigger
    fetch(32'h8010);
    wr(2, 32'h6);               // rewrite disarms
    fetch(32'h404);

    curReq = "R11";
    wr(9, 32'h0); wr(3, 32'h3);
    fetch(32'h404);
    tick(); tick();
    execDone = 1; tick(); execDone = 0;
    clr();
    fetch(32'h404, 8'h00, 16'h0, 1'b1);   // strobe in fetch cycle belongs to older work
    execDone = 1; tick(); execDone = 0;
    clr();

    curReq = "R10";
    fetch(32'h8016);

    curReq = "R12";
    tick(); tick();
    brkClr = 1; fetchValid = 1; fetchAddr = 32'h8010; tick();
    brkClr = 0; fetchValid = 0;
    tick(); clr(); tick();

    curReq = "mixed";
    for (int i = 0; i < 1500; i++) begin
      logic [3:0] a;
      fetchValid = ($urandom % 3) != 0;
      fetchAddr  = ($urandom % 4 == 0) ? 32'h404 : (32'h8010 + ($urandom % 16));
      fetchAsid  = ($urandom % 2) ? 8'h70 : 8'h80;
      fetchData  = 16'(($urandom % 2) ? 16'hAB00 + ($urandom % 256) : $urandom);
      execDone   = ($urandom % 3) == 0;
      brkClr     = ($urandom % 6) == 0;
      regWe      = ($urandom % 12) == 0;
      a = 4'($urandom % 10);
      regAddr = a;
      case (a)
        4'd0, 4'd3: regWdata = {16'h0, (($urandom % 2) ? 8'h70 : 8'h80), 3'b0, 5'($urandom) | 5'h1};
        4'd1:       regWdata = 32'h8010;
        4'd4:       regWdata = ($urandom % 2) ? 32'h404 : 32'h8014;
        4'd2, 4'd5: regWdata = $urandom % 16;
        4'd6:       regWdata = 32'hAB00;
        4'd7:       regWdata = 32'hFF;
        4'd8:       regWdata = $urandom % 5;
        default:    regWdata = $urandom % 2;
      endcase
      tick();
    end
    regWe = 0; fetchValid = 0; execDone = 0; brkClr = 0;
    tick();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule